// File: doc/BRIEF.md
# Banked Gray-Shade Palette Lookup

This block turns each incoming pixel code into a 4-bit gray-shade weight through a small programmable table of sixteen entries. A display pipeline places a pixel code and a depth-mode flag on its inputs. One clock later the block returns the shade that software stored for that code. In the 4-bits-per-pixel depth the pixel code selects any of the sixteen entries directly.

In the 2-bits-per-pixel depth the same sixteen entries act as four separate palettes of four shades each. A 2-bit bank field chooses the palette in use, so software can switch the whole shade mapping by rewriting two bits instead of reloading entries.

Software reaches the block through a 4-bit index bus that selects one of sixteen byte-wide locations. Index 14 is a control register that holds the bank field, a fixed two-bit revision code and a 4-bit entry pointer. Index 15 is a data port that reads or writes the entry the pointer names, and every access to it advances the pointer.

Top module: `gray_palette_lut`

## Requirements
- R1: After reset the entry pointer and the bank field are 0, entry i holds the value i for every i in 0..15, and shade_out is 0.
- R2: When depth_4bpp is 1, shade_out at clock edge n+1 equals the entry selected by pix_in[3:0] as sampled at edge n.
- R3: When depth_4bpp is 0, the entry used is {bank[1:0], pix_in[1:0]}, so bank b covers entries 4b to 4b+3, and pix_in[3:2] has no effect.
- R4: When depth_4bpp is 1, the bank field has no effect on shade_out.
- R5: A write to index 14 (1110b) loads bank from cpu_wdata[7:6] and the pointer from cpu_wdata[3:0]. While cpu_addr is 14, cpu_rdata shows {bank, ID, pointer} in bits [7:6], [5:4] and [3:0].
- R6: cpu_rdata[5:4] at index 14 always reads the ID_CODE parameter (default 2'b10). Writes to index 14 never change it.
- R7: A write to index 15 stores cpu_wdata[3:0] in the entry the pointer names. While cpu_addr is 15, cpu_rdata is {4'b0000, that entry}.
- R8: Each clock cycle that has cpu_wr or cpu_rd at index 15 advances the pointer by exactly one, and the pointer wraps from 15 to 0. Reads and writes at index 14 do not advance it.
- R9: At indices 0 to 13, cpu_rdata is 0 and writes change neither the pointer, the bank field nor any entry.
- R10: A lookup in the same cycle as a data-port write to the entry it selects returns the old value. The new value appears from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 4 | Register index for software access |
| cpu_wr | input | 1 | Write strobe, one access per cycle |
| cpu_rd | input | 1 | Read strobe, one access per cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the current index (combinational) |
| depth_4bpp | input | 1 | 1: 4 bits per pixel, 0: 2 bits per pixel with banks |
| pix_in | input | 4 | Pixel code to translate |
| shade_out | output | 4 | Registered gray-shade weight |

## Verification
The bench sweeps every pixel code in both depths under all four bank settings. A design that folded the bank into the 4-bit index, or that dropped pix_in[3:2] in the wrong mode, would return shades from the wrong entries. It reads the data port past entry 15 to catch a pointer that saturates or fails to wrap, and it writes all-ones to the control register to catch revision bits that can be overwritten. It writes an entry in the same cycle a pixel looks it up, and it writes to unused indices, exposing a write-through lookup or a sloppy address decode.

// File: rtl/gpl_pkg.sv
package gpl_pkg;
    localparam int NUM_ENT  = 16;
    localparam int IDX_W    = $clog2(NUM_ENT);
    localparam int SHADE_W  = 4;
    localparam int NUM_BANK = 4;
    localparam int BANK_W   = $clog2(NUM_BANK);
    localparam int SUB_W    = IDX_W - BANK_W;
    localparam int REG_W    = 8;
    localparam int ID_W     = REG_W - BANK_W - IDX_W;
    localparam int ADDR_W   = 4;

    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [SHADE_W-1:0] shade_t;
    typedef logic [BANK_W-1:0]  bank_t;
    typedef logic [ID_W-1:0]    id_t;
    typedef logic [REG_W-1:0]   reg_t;
    typedef logic [ADDR_W-1:0]  addr_t;

    // control register state: bank field and entry pointer
    typedef struct packed {
        bank_t bank;
        idx_t  ptr;
    } ctrl_t;

    typedef shade_t [NUM_ENT-1:0] tbl_t;

    // readback layout: bank in the top bits, revision code, then pointer
    function automatic reg_t pack_ctrl(ctrl_t c, id_t id);
        return {c.bank, id, c.ptr};
    endfunction
endpackage

// File: rtl/gpl_ctrl.sv
module gpl_ctrl
    import gpl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld_en,
    input  bank_t ld_bank,
    input  idx_t  ld_ptr,
    input  logic  step_en,
    output ctrl_t ctrl
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ld_en) begin
            ctrl_d.bank = ld_bank;
            ctrl_d.ptr  = ld_ptr;
        end else if (step_en) begin
            ctrl_d.ptr = ctrl_q.ptr + idx_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/gpl_store.sv
module gpl_store
    import gpl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  idx_t   wr_idx,
    input  shade_t wr_val,
    input  idx_t   cpu_idx,
    output shade_t cpu_entry,
    input  idx_t   lut_idx,
    output shade_t lut_entry,
    output tbl_t   tbl
);
    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) tbl_d[wr_idx] = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++) tbl_q[i] <= shade_t'(i);
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // both read ports see the state before this cycle's write
    assign cpu_entry = tbl_q[cpu_idx];
    assign lut_entry = tbl_q[lut_idx];
    assign tbl       = tbl_q;
endmodule

// File: rtl/gpl_lookup.sv
module gpl_lookup
    import gpl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wide_mode,
    input  bank_t  bank,
    input  idx_t   pix,
    output idx_t   lut_idx,
    input  shade_t lut_entry,
    output shade_t shade
);
    typedef struct packed {
        shade_t shade;
    } look_t;

    look_t look_d, look_q;

    always_comb begin
        if (wide_mode) lut_idx = pix;
        else           lut_idx = {bank, pix[SUB_W-1:0]};
        look_d.shade = lut_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) look_q <= '0;
        else        look_q <= look_d;
    end

    assign shade = look_q.shade;
endmodule

// File: rtl/gray_palette_lut.sv
module gray_palette_lut
    import gpl_pkg::*;
#(
    parameter id_t   ID_CODE  = 2'b10,
    parameter addr_t CTRL_IDX = 4'hE,
    parameter addr_t DATA_IDX = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    input  logic              depth_4bpp,
    input  logic [IDX_W-1:0]  pix_in,
    output logic [SHADE_W-1:0] shade_out
);
    logic   hit_ctrl, hit_data;
    logic   ctrl_ld, data_wr, data_step;
    ctrl_t  ctrl_cur;
    tbl_t   tbl_cur;
    shade_t cpu_entry, lut_entry;
    idx_t   lut_idx;

    always_comb begin
        hit_ctrl  = (cpu_addr == CTRL_IDX);
        hit_data  = (cpu_addr == DATA_IDX);
        ctrl_ld   = cpu_wr & hit_ctrl;
        data_wr   = cpu_wr & hit_data;
        data_step = (cpu_wr | cpu_rd) & hit_data;
    end

    gpl_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ctrl_ld),
        .ld_bank (cpu_wdata[REG_W-1 -: BANK_W]),
        .ld_ptr  (cpu_wdata[IDX_W-1:0]),
        .step_en (data_step),
        .ctrl    (ctrl_cur)
    );

    gpl_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr),
        .wr_idx    (ctrl_cur.ptr),
        .wr_val    (cpu_wdata[SHADE_W-1:0]),
        .cpu_idx   (ctrl_cur.ptr),
        .cpu_entry (cpu_entry),
        .lut_idx   (lut_idx),
        .lut_entry (lut_entry),
        .tbl       (tbl_cur)
    );

    gpl_lookup u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_mode (depth_4bpp),
        .bank      (ctrl_cur.bank),
        .pix       (pix_in),
        .lut_idx   (lut_idx),
        .lut_entry (lut_entry),
        .shade     (shade_out)
    );

    always_comb begin
        cpu_rdata = '0;
        if (hit_ctrl)      cpu_rdata = pack_ctrl(ctrl_cur, ID_CODE);
        else if (hit_data) cpu_rdata = {{(REG_W-SHADE_W){1'b0}}, cpu_entry};
    end
endmodule

// File: rtl/gpl_chk.sv
module gpl_chk
    import gpl_pkg::*;
#(
    parameter id_t   ID_CODE  = 2'b10,
    parameter addr_t CTRL_IDX = 4'hE,
    parameter addr_t DATA_IDX = 4'hF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [REG_W-1:0]  cpu_wdata,
    input logic [REG_W-1:0]  cpu_rdata,
    input logic              depth_4bpp,
    input logic [IDX_W-1:0]  pix_in,
    input logic [SHADE_W-1:0] shade_out,
    input ctrl_t             ctrl,
    input tbl_t              tbl
);
    localparam reg_t ID_MASK = reg_t'({ID_W{1'b1}}) << IDX_W;
    localparam reg_t ID_BITS = reg_t'(ID_CODE) << IDX_W;

    logic   at_ctrl, at_data, at_other;
    idx_t   want_idx;
    shade_t want_entry;

    always_comb begin
        at_ctrl    = cpu_addr == CTRL_IDX;
        at_data    = cpu_addr == DATA_IDX;
        at_other   = !at_ctrl && !at_data;
        want_idx   = depth_4bpp ? pix_in : idx_t'({ctrl.bank, pix_in[SUB_W-1:0]});
        want_entry = tbl[want_idx];
    end

    AST_SHADE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> shade_out == $past(want_entry)); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_data && (cpu_wr || cpu_rd)) |=> ctrl.ptr == $past(ctrl.ptr) + idx_t'(1)); // R8

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (at_ctrl && cpu_wr) |=> pack_ctrl(ctrl, ID_CODE) == (($past(cpu_wdata) & ~ID_MASK) | ID_BITS)); // R5

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        at_ctrl |-> cpu_rdata[IDX_W +: ID_W] == ID_CODE); // R6

    AST_DATA_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (at_data && cpu_wr) |=> tbl[$past(ctrl.ptr)] == $past(cpu_wdata[SHADE_W-1:0])); // R7

    AST_OTHER_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (at_other && cpu_wr) |=> (ctrl == $past(ctrl)) && (tbl == $past(tbl))); // R9

    AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        at_other |-> cpu_rdata == '0); // R9

    AST_NO_CTRL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_ctrl && cpu_rd && !cpu_wr) |=> $stable(ctrl)); // R8
endmodule

bind gray_palette_lut gpl_chk #(
    .ID_CODE  (ID_CODE),
    .CTRL_IDX (CTRL_IDX),
    .DATA_IDX (DATA_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wr     (cpu_wr),
    .cpu_rd     (cpu_rd),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .depth_4bpp (depth_4bpp),
    .pix_in     (pix_in),
    .shade_out  (shade_out),
    .ctrl       (ctrl_cur),
    .tbl        (tbl_cur)
);

// File: tb/gray_palette_lut_bench.sv
`timescale 1ns/1ps
module gray_palette_lut_bench;
    localparam int ID_EXP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       depth_4bpp = 1'b1;
    logic [3:0] pix_in = '0;
    logic [3:0] shade_out;

    always #2.5 clk = ~clk;

    gray_palette_lut u_gray_palette_lut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .depth_4bpp (depth_4bpp),
        .pix_in     (pix_in),
        .shade_out  (shade_out)
    );

    int total = 0;
    int bad = 0;
    int ref_tbl [16];
    int ref_bank, ref_ptr, ref_shade;
    string tag_sh = "R2";
    string tag_rd = "R7";

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_rdata();
        if (cpu_addr == 4'hE) return ref_bank * 64 + ID_EXP * 16 + ref_ptr;
        if (cpu_addr == 4'hF) return ref_tbl[ref_ptr];
        return 0;
    endfunction

    // one clock: check read data, step the model at the edge, check shade after it
    task automatic tick();
        int idx;
        int nxt;
        #1;
        if (cpu_rd) chk(tag_rd, int'(cpu_rdata), model_rdata());
        @(posedge clk);
        idx = depth_4bpp ? int'(pix_in) : ref_bank * 4 + int'(pix_in) % 4;
        nxt = ref_tbl[idx];
        if (cpu_wr && cpu_addr == 4'hE) begin
            ref_bank = int'(cpu_wdata[7:6]);
            ref_ptr  = int'(cpu_wdata[3:0]);
        end else if (cpu_addr == 4'hF && (cpu_wr || cpu_rd)) begin
            if (cpu_wr) ref_tbl[ref_ptr] = int'(cpu_wdata[3:0]);
            ref_ptr = (ref_ptr + 1) % 16;
        end
        ref_shade = nxt;
        @(negedge clk);
        chk(tag_sh, int'(shade_out), ref_shade);
    endtask

    task automatic reg_write(logic [3:0] a, logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        tick();
        cpu_wr = 1'b0;
    endtask

    task automatic reg_read(logic [3:0] a, string req);
        tag_rd = req;
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        tick();
        cpu_rd = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog R1..all actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 16; i++) ref_tbl[i] = i;
        ref_bank = 0; ref_ptr = 0; ref_shade = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 shade after reset", int'(shade_out), 0);
        tag_sh = "R1 R2";
        reg_read(4'hE, "R1 R5 R6 control readback");

        // R1 R7 R8: read all entries in sequence, then wrap
        for (int i = 0; i < 17; i++) reg_read(4'hF, "R1 R7 R8 sequential read");
        reg_read(4'hE, "R8 pointer after wrap");

        // R7 R8: load a new table through the data port
        reg_write(4'hE, 8'h00);
        for (int i = 0; i < 16; i++) reg_write(4'hF, 8'(((i * 7) + 3) % 16) | 8'hA0);
        reg_read(4'hE, "R8 pointer wrapped after 16 writes");
        for (int i = 0; i < 16; i++) reg_read(4'hF, "R7 readback of written table");

        // R5 R6: all-ones into control keeps revision code
        reg_write(4'hE, 8'hFF);
        reg_read(4'hE, "R5 R6 control after all-ones write");
        reg_write(4'hE, 8'h4A);
        reg_read(4'hE, "R5 control load bank 1 ptr 10");

        // R2 R4: 4bpp sweep under every bank
        tag_sh = "R2 R4 4bpp lookup";
        depth_4bpp = 1'b1;
        for (int b = 0; b < 4; b++) begin
            reg_write(4'hE, 8'(b << 6));
            for (int p = 0; p < 16; p++) begin pix_in = 4'(p); tick(); end
        end

        // R3: 2bpp sweep under every bank, upper pixel bits toggling
        tag_sh = "R3 2bpp banked lookup";
        depth_4bpp = 1'b0;
        for (int b = 0; b < 4; b++) begin
            reg_write(4'hE, 8'(b << 6) | 8'h05);
            for (int p = 0; p < 16; p++) begin pix_in = 4'(p); tick(); end
        end

        // R9: unused indices
        tag_sh = "R9 shade";
        reg_write(4'h3, 8'hFF);
        reg_write(4'h0, 8'hC7);
        reg_read(4'h3, "R9 unused index reads zero");
        reg_read(4'hD, "R9 unused index reads zero");
        reg_read(4'hE, "R9 control unchanged");
        reg_read(4'hF, "R9 entry unchanged");

        // R10: lookup and write to the same entry in one cycle
        tag_sh = "R10 old value then new";
        depth_4bpp = 1'b1;
        reg_write(4'hE, 8'h06);
        pix_in = 4'h6;
        tick();
        cpu_addr = 4'hF; cpu_wdata = 8'h0C; cpu_wr = 1'b1;
        tick();
        cpu_wr = 1'b0;
        tick();
        tick();

        // mixed traffic
        tag_sh = "R2 R3 R8 mixed shade";
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pix_in     = lfsr[3:0];
            depth_4bpp = lfsr[4];
            cpu_addr   = lfsr[6] ? 4'hF : (lfsr[7] ? 4'hE : lfsr[11:8]);
            cpu_wr     = lfsr[5] & lfsr[9];
            cpu_rd     = lfsr[12];
            cpu_wdata  = {lfsr[15:12], lfsr[3:0]};
            tag_rd     = "R5 R7 R9 mixed read";
            tick();
        end
        cpu_wr = 1'b0; cpu_rd = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule